// File: doc/BRIEF.md
# Six-Step Motor Output Manager

This block takes a single PWM signal and places it on six motor drive channels for six-step (trapezoidal) commutation. Channels 0 to 2 are the high-side switches of pairs 0 to 2, and channels 3 to 5 are the low-side switches of the same pairs. Channel `k` and channel `k+3` drive the same half bridge.

A six-bit phase pattern selects which channels take part in the current commutation step. Two routing controls choose whether the PWM modulates the high group, the low group or both. When both groups carry PWM, a mode bit picks one of two schemes:
- simultaneous: both groups follow the PWM;
- alternate: the low group follows the inverted PWM, so each half bridge is driven complementarily.

Each half bridge has its own dead-time guard. The guard holds off the turn-on of a switch until its partner has been off for a programmed number of clocks. After the guard, the block applies three further stages to the switch states, in this order:
1. an optional high-frequency chopper, combined by AND;
2. a polarity inversion, set per channel;
3. a safe-state override.

The safe state can be requested by an active-low software force input or by an active-low emergency-stop pin. The emergency-stop pin acts without any clock. A synchronised copy of it also sets a sticky fault flag. While that flag is set, the outputs stay safe until software clears it.

Top module: `motor_drive_steer`

## Requirements
- R1: With `route_high`=1 and `route_low`=0, an enabled high channel is active exactly when `pwm_in` was 1 at the previous clock edge. An enabled low channel is active regardless of `pwm_in`.
- R2: With `route_high`=0 and `route_low`=1, an enabled low channel follows `pwm_in` one clock later. An enabled high channel is statically active.
- R3: With both routing bits set and `alt_mode`=0, enabled high and low channels both follow `pwm_in`.
- R4: With both routing bits set and `alt_mode`=1, enabled high channels follow `pwm_in` and enabled low channels follow its inverse.
- R5: The two channels of a pair are never both active. After one switch of a pair turns off, its partner turns on no earlier than max(`dead_cycles`,1) clock edges later.
- R6: If both channels of an idle pair request turn-on at the same edge, only the high channel (bit k) turns on.
- R7: `phase_en` bit i (bits 0..2 = high channels of pairs 0..2, bits 3..5 = low channels) at 0 keeps channel i inactive at the next edge.
- R8: With `chop_en`=1, an active channel drives its active level only while `chop_in` is 1. This gating is combinational.
- R9: In normal operation, `drive_lvl[i]` equals channel i's gated state XOR `polarity[i]`, and `drive_oe` is all ones.
- R10: While `sw_force_n`=0, every output takes the safe state set by `safe_sel`:
  - 00 or 11: `drive_oe`=0 and `drive_lvl`=0;
  - 01: all low, with `drive_oe`=all ones;
  - 10: all high, with `drive_oe`=all ones.
  All switch states are cleared during the force.
- R11: `estop_n`=0 applies the R10 safe state combinationally, without a clock edge.
- R12: A synchronised low on `estop_n` sets `fault_flag`.
  - The flag stays set, and the outputs stay in the safe state, until `fault_clr` is pulsed while the synchronised `estop_n` is high.
  - `fault_clr` has no effect while the stop is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM signal to steer |
| phase_en | input | 6 | Phase pattern: bits 0..2 high channels, bits 3..5 low channels |
| route_high | input | 1 | Modulate high group with PWM |
| route_low | input | 1 | Modulate low group with PWM |
| alt_mode | input | 1 | 1: low group uses inverted PWM when both groups are routed |
| dead_cycles | input | 8 | Dead time in clock cycles |
| chop_en | input | 1 | Enable chopper gating |
| chop_in | input | 1 | High-frequency chopper signal |
| polarity | input | 6 | Per-channel output inversion |
| sw_force_n | input | 1 | Active-low software force to safe state |
| estop_n | input | 1 | Active-low asynchronous emergency stop |
| safe_sel | input | 2 | Safe state: 00 high impedance, 01 low, 10 high, 11 high impedance |
| fault_clr | input | 1 | Clears the sticky fault flag |
| drive_lvl | output | 6 | Channel output levels |
| drive_oe | output | 6 | Channel output enables (0 = high impedance) |
| fault_flag | output | 1 | Sticky emergency-stop fault |

## Verification
The hardest behaviour to reach is the dead-time hand-over inside one half bridge. It needs both switches of the same pair enabled together while the PWM flips between them. Six-step patterns normally enable switches of different pairs, so they never produce this case. The stimulus therefore enables the high and low switch of pair 0 together in alternate mode and toggles the PWM with a dead time of 3 and then 0, checking the exact clock at which each partner comes on. The tie case of R6 is reached by idling the pair and then enabling both switches with no routing.

// File: rtl/mds_pkg.sv
package mds_pkg;
    typedef enum logic [1:0] {
        SAFE_HIZ  = 2'b00,
        SAFE_LOW  = 2'b01,
        SAFE_HIGH = 2'b10,
        SAFE_RSVD = 2'b11
    } safe_e;

    typedef struct packed {
        logic to_high;
        logic to_low;
        logic alt;
    } route_t;
endpackage

// File: rtl/mds_route.sv
module mds_route
    import mds_pkg::*;
#(
    parameter int NPAIR = 3
) (
    input  logic               pwm,
    input  logic [2*NPAIR-1:0] phase_en,
    input  route_t             route,
    output logic [2*NPAIR-1:0] req
);
    logic gate_hi;
    logic gate_lo;

    always_comb begin
        gate_hi = route.to_high ? pwm : 1'b1;
        if (route.to_low)
            gate_lo = (route.to_high && route.alt) ? ~pwm : pwm;
        else
            gate_lo = 1'b1;
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign req[k]         = phase_en[k] & gate_hi;
        assign req[k + NPAIR] = phase_en[k + NPAIR] & gate_lo;
    end
endmodule

// File: rtl/mds_deadband.sv
module mds_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            req_hi,
    input  logic            req_lo,
    input  logic [DT_W-1:0] dead,
    output logic            act_hi,
    output logic            act_lo
);
    localparam logic [DT_W-1:0] ONE = 1;

    typedef struct packed {
        logic            act_hi;
        logic            act_lo;
        logic [DT_W-1:0] off_hi;
        logic [DT_W-1:0] off_lo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.act_hi = !hold && req_hi && !st_q.act_lo && (st_q.off_lo >= dead);
        st_d.act_lo = !hold && req_lo && !st_q.act_hi && !st_d.act_hi
                      && (st_q.off_hi >= dead);
        if (st_d.act_hi)
            st_d.off_hi = '0;
        else if (st_q.off_hi != '1)
            st_d.off_hi = st_q.off_hi + ONE;
        if (st_d.act_lo)
            st_d.off_lo = '0;
        else if (st_q.off_lo != '1)
            st_d.off_lo = st_q.off_lo + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{act_hi: 1'b0, act_lo: 1'b0, off_hi: '1, off_lo: '1};
        else
            st_q <= st_d;
    end

    assign act_hi = st_q.act_hi;
    assign act_lo = st_q.act_lo;
endmodule

// File: rtl/mds_fault.sv
module mds_fault #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n,
    input  logic clr,
    output logic fault
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   fault;
    } st_t;

    st_t st_d, st_q;
    logic stop_s;

    assign stop_s = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], stop_n};
        if (!stop_s)
            st_d.fault = 1'b1;
        else if (clr)
            st_d.fault = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{sync: '1, fault: 1'b0};
        else
            st_q <= st_d;
    end

    assign fault = st_q.fault;
endmodule

// File: rtl/mds_outstage.sv
module mds_outstage
    import mds_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0] act,
    input  logic           chop_en,
    input  logic           chop_in,
    input  logic [NCH-1:0] pol,
    input  logic           safe_now,
    input  logic [1:0]     safe_sel,
    output logic [NCH-1:0] lvl,
    output logic [NCH-1:0] oe
);
    logic [NCH-1:0] gated;

    always_comb begin
        gated = chop_en ? (act & {NCH{chop_in}}) : act;
        lvl   = gated ^ pol;
        oe    = '1;
        if (safe_now) begin
            unique case (safe_e'(safe_sel))
                SAFE_LOW:  begin lvl = '0; oe = '1; end
                SAFE_HIGH: begin lvl = '1; oe = '1; end
                default:   begin lvl = '0; oe = '0; end
            endcase
        end
    end
endmodule

// File: rtl/motor_drive_steer.sv
module motor_drive_steer
    import mds_pkg::*;
#(
    parameter int NPAIR       = 3,
    parameter int DT_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwm_in,
    input  logic [2*NPAIR-1:0]   phase_en,
    input  logic                 route_high,
    input  logic                 route_low,
    input  logic                 alt_mode,
    input  logic [DT_W-1:0]      dead_cycles,
    input  logic                 chop_en,
    input  logic                 chop_in,
    input  logic [2*NPAIR-1:0]   polarity,
    input  logic                 sw_force_n,
    input  logic                 estop_n,
    input  logic [1:0]           safe_sel,
    input  logic                 fault_clr,
    output logic [2*NPAIR-1:0]   drive_lvl,
    output logic [2*NPAIR-1:0]   drive_oe,
    output logic                 fault_flag
);
    localparam int NCH = 2 * NPAIR;

    route_t         route;
    logic [NCH-1:0] req;
    logic [NCH-1:0] act;
    logic           hold;
    logic           safe_now;

    assign route    = '{to_high: route_high, to_low: route_low, alt: alt_mode};
    assign hold     = ~sw_force_n | fault_flag;
    assign safe_now = ~sw_force_n | ~estop_n | fault_flag;

    mds_route #(.NPAIR(NPAIR)) u_route (
        .pwm      (pwm_in),
        .phase_en (phase_en),
        .route    (route),
        .req      (req)
    );

    for (genvar k = 0; k < NPAIR; k++) begin : g_bridge
        mds_deadband #(.DT_W(DT_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (hold),
            .req_hi (req[k]),
            .req_lo (req[k + NPAIR]),
            .dead   (dead_cycles),
            .act_hi (act[k]),
            .act_lo (act[k + NPAIR])
        );
    end

    mds_fault #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .stop_n (estop_n),
        .clr    (fault_clr),
        .fault  (fault_flag)
    );

    mds_outstage #(.NCH(NCH)) u_out (
        .act      (act),
        .chop_en  (chop_en),
        .chop_in  (chop_in),
        .pol      (polarity),
        .safe_now (safe_now),
        .safe_sel (safe_sel),
        .lvl      (drive_lvl),
        .oe       (drive_oe)
    );
endmodule

// File: rtl/mds_checker.sv
module mds_checker #(
    parameter int NPAIR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               estop_n,
    input logic               fault_clr,
    input logic [1:0]         safe_sel,
    input logic [2*NPAIR-1:0] phase_en,
    input logic [2*NPAIR-1:0] act,
    input logic [2*NPAIR-1:0] drive_lvl,
    input logic [2*NPAIR-1:0] drive_oe,
    input logic               fault_flag
);
    localparam int NCH = 2 * NPAIR;

    logic [NCH-1:0] safe_lvl;
    logic [NCH-1:0] safe_oe;
    logic           outputs_safe;

    always_comb begin
        safe_lvl     = (safe_sel == 2'b10) ? '1 : '0;
        safe_oe      = (safe_sel == 2'b01 || safe_sel == 2'b10) ? '1 : '0;
        outputs_safe = (drive_lvl == safe_lvl) && (drive_oe == safe_oe);
    end

    // R5 / R6: the two switches of a pair are never on together
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act[NPAIR-1:0] & act[NCH-1:NPAIR]) == '0);

    // R5: a low switch never turns on while its high partner was on one cycle earlier
    p_dead_gap_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((act[NCH-1:NPAIR] & ~$past(act[NCH-1:NPAIR])) & $past(act[NPAIR-1:0])) == '0);

    // R5: a high switch never turns on while its low partner was on one cycle earlier
    p_dead_gap_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((act[NPAIR-1:0] & ~$past(act[NPAIR-1:0])) & $past(act[NCH-1:NPAIR])) == '0);

    // R7: a disabled channel stays inactive after the edge
    p_phase_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act & ~$past(phase_en)) == '0);

    // R11: emergency stop puts the outputs in the safe state
    p_estop_safe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !estop_n |-> outputs_safe);

    // R12: the fault flag stays set while no clear request is made
    p_fault_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clr) |=> fault_flag);

    // R12: the outputs stay safe while the fault flag is set
    p_fault_safe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> outputs_safe);
endmodule

bind motor_drive_steer mds_checker #(.NPAIR(NPAIR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .estop_n    (estop_n),
    .fault_clr  (fault_clr),
    .safe_sel   (safe_sel),
    .phase_en   (phase_en),
    .act        (act),
    .drive_lvl  (drive_lvl),
    .drive_oe   (drive_oe),
    .fault_flag (fault_flag)
);

// File: tb/motor_drive_steer_bench.sv
module motor_drive_steer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic [5:0] phase_en = '0;
    logic       route_high = 1'b0;
    logic       route_low = 1'b0;
    logic       alt_mode = 1'b0;
    logic [7:0] dead_cycles = '0;
    logic       chop_en = 1'b0;
    logic       chop_in = 1'b0;
    logic [5:0] polarity = '0;
    logic       sw_force_n = 1'b1;
    logic       estop_n = 1'b1;
    logic [1:0] safe_sel = 2'b00;
    logic       fault_clr = 1'b0;
    logic [5:0] drive_lvl;
    logic [5:0] drive_oe;
    logic       fault_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [5:0] lvl;
        logic [5:0] oe;
        logic       flt;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    motor_drive_steer u_motor_drive_steer (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .phase_en(phase_en),
        .route_high(route_high), .route_low(route_low), .alt_mode(alt_mode),
        .dead_cycles(dead_cycles), .chop_en(chop_en), .chop_in(chop_in),
        .polarity(polarity), .sw_force_n(sw_force_n), .estop_n(estop_n),
        .safe_sel(safe_sel), .fault_clr(fault_clr), .drive_lvl(drive_lvl),
        .drive_oe(drive_oe), .fault_flag(fault_flag)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (drive_lvl !== it.lvl || drive_oe !== it.oe || fault_flag !== it.flt) begin
                    errors++;
                    $display("FAIL %s: lvl=%b oe=%b fault=%b expected lvl=%b oe=%b fault=%b",
                             it.tag, drive_lvl, drive_oe, fault_flag, it.lvl, it.oe, it.flt);
                end
            end
        end
    end

    task automatic expect_out(string tag, logic [5:0] l, logic [5:0] o, logic f);
        sb_q.push_back('{tag, l, o, f});
        ->chk_ev;
        #0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        expect_out("reset R9", 6'b000000, 6'h3F, 1'b0);

        // R1: high group modulated, pair0 high + pair1 low enabled
        phase_en = 6'b010001; route_high = 1; route_low = 0; pwm_in = 1;
        tick(1); expect_out("R1 pwm=1", 6'b010001, 6'h3F, 1'b0);
        pwm_in = 0;
        tick(1); expect_out("R1 pwm=0", 6'b010000, 6'h3F, 1'b0);

        // R2: low group modulated
        route_high = 0; route_low = 1; pwm_in = 1;
        tick(1); expect_out("R2 pwm=1", 6'b010001, 6'h3F, 1'b0);
        pwm_in = 0;
        tick(1); expect_out("R2 pwm=0", 6'b000001, 6'h3F, 1'b0);

        // R3: both groups, simultaneous
        route_high = 1; route_low = 1; alt_mode = 0;
        tick(1); expect_out("R3 pwm=0", 6'b000000, 6'h3F, 1'b0);
        pwm_in = 1;
        tick(1); expect_out("R3 pwm=1", 6'b010001, 6'h3F, 1'b0);

        // R4: both groups, alternate
        alt_mode = 1;
        tick(1); expect_out("R4 pwm=1", 6'b000001, 6'h3F, 1'b0);
        pwm_in = 0;
        tick(1); expect_out("R4 pwm=0", 6'b010000, 6'h3F, 1'b0);

        // R7: phase bits gate channels
        phase_en = 6'b000000; pwm_in = 1; alt_mode = 0;
        tick(1); expect_out("R7 all disabled", 6'b000000, 6'h3F, 1'b0);
        phase_en = 6'b100010; route_high = 0; route_low = 0;
        tick(1); expect_out("R7 static pattern", 6'b100010, 6'h3F, 1'b0);

        // R9: polarity
        polarity = 6'b000011;
        tick(1); expect_out("R9 polarity", 6'b100001, 6'h3F, 1'b0);
        polarity = 6'b000000;

        // R8: chopper
        chop_en = 1; chop_in = 0;
        tick(1); expect_out("R8 chop low", 6'b000000, 6'h3F, 1'b0);
        chop_in = 1;
        #1; expect_out("R8 chop high", 6'b100010, 6'h3F, 1'b0);
        chop_en = 0;

        // R6: tie in an idle pair
        phase_en = 6'b000000;
        tick(2);
        phase_en = 6'b001001;
        tick(1); expect_out("R6 tie high wins", 6'b000001, 6'h3F, 1'b0);
        tick(1); expect_out("R6 tie held", 6'b000001, 6'h3F, 1'b0);

        // R5: dead time within pair 0, alternate routing
        route_high = 1; route_low = 1; alt_mode = 1; dead_cycles = 8'd3; pwm_in = 1;
        tick(2); expect_out("R5 high steady", 6'b000001, 6'h3F, 1'b0);
        pwm_in = 0;
        tick(1); expect_out("R5 gap 1", 6'b000000, 6'h3F, 1'b0);
        tick(1); expect_out("R5 gap 2", 6'b000000, 6'h3F, 1'b0);
        tick(1); expect_out("R5 gap 3", 6'b000000, 6'h3F, 1'b0);
        tick(1); expect_out("R5 low on", 6'b001000, 6'h3F, 1'b0);
        pwm_in = 1;
        tick(3); expect_out("R5 back gap", 6'b000000, 6'h3F, 1'b0);
        tick(1); expect_out("R5 high on", 6'b000001, 6'h3F, 1'b0);
        dead_cycles = 8'd0; pwm_in = 0;
        tick(1); expect_out("R5 zero dead gap", 6'b000000, 6'h3F, 1'b0);
        tick(1); expect_out("R5 zero dead on", 6'b001000, 6'h3F, 1'b0);

        // R10: software force
        sw_force_n = 0; safe_sel = 2'b01;
        #1; expect_out("R10 safe low", 6'b000000, 6'h3F, 1'b0);
        safe_sel = 2'b10;
        #1; expect_out("R10 safe high", 6'h3F, 6'h3F, 1'b0);
        safe_sel = 2'b00;
        #1; expect_out("R10 safe hiz", 6'b000000, 6'h00, 1'b0);
        safe_sel = 2'b11;
        tick(2); expect_out("R10 safe code 11", 6'b000000, 6'h00, 1'b0);
        safe_sel = 2'b00; sw_force_n = 1;
        #1; expect_out("R10 released, state cleared", 6'b000000, 6'h3F, 1'b0);
        tick(1); expect_out("R10 resumes", 6'b001000, 6'h3F, 1'b0);

        // R11: asynchronous emergency stop
        tick(1);
        #2; estop_n = 0;
        #1; expect_out("R11 async safe", 6'b000000, 6'h00, 1'b0);
        tick(4); expect_out("R12 fault set", 6'b000000, 6'h00, 1'b1);
        fault_clr = 1;
        tick(1); fault_clr = 0;
        expect_out("R12 clear ignored during stop", 6'b000000, 6'h00, 1'b1);
        estop_n = 1;
        tick(4); expect_out("R12 still safe after release", 6'b000000, 6'h00, 1'b1);
        fault_clr = 1;
        tick(1); fault_clr = 0;
        expect_out("R12 cleared", 6'b000000, 6'h3F, 1'b0);
        tick(1); expect_out("R12 normal again", 6'b001000, 6'h3F, 1'b0);

        tick(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule